// File: doc/BRIEF.md
# Ping-Pong Transmit Handoff Controller

This block sits on the device side of a host-to-device transmit path that uses exactly two fixed frame buffers. Successive packets alternate between the two buffers. The host advances an input count each time it finishes copying a packet and rings a doorbell. The device advances an output count each time a downstream consumer finishes draining a buffer. Flow control comes from the difference of these two free-running 4-bit counts taken modulo 16, not from a FIFO pointer pair, so wrapping of either count never produces a false full indication.

The host side is plain control and status. `host_free` tells the host whether a slot is open, and `host_wr_sel` says which buffer to fill next. `stat_out_cnt` exposes the output count. A doorbell carries the byte length of the packet just copied. The block rounds that length up to a multiple of 4 and records it for the buffer the packet went into. A doorbell is rejected and reported when both buffers are already occupied, or when the rounded length does not fit a buffer.

The consumer side is a valid/ready stream. `cons_valid` is high whenever at least one buffer holds an undrained packet. `cons_sel` and `cons_len` describe the oldest such buffer and stay stable while `cons_valid` is high and `cons_ready` is low. A handshake (`cons_valid` and `cons_ready` both high at a clock edge) means the consumer has finished reading that buffer, and the output count advances at that edge. The consumer may hold `cons_ready` low for any number of cycles. `cons_ready` has no effect while `cons_valid` is low.

Top module: `txpp_handoff`

## Requirements
- R1: While `rst_n` is low, and before any traffic, both counts are 0. So `host_free`=1, `host_wr_sel`=0, `stat_out_cnt`=0, `cons_valid`=0, `cons_sel`=0, `ovf_err`=0 and `len_err`=0.
- R2: `host_free` is 1 exactly when (input count − output count) mod 16 is less than 2.
- R3: A doorbell that is accepted advances the input count by 1 modulo 16 at that clock edge. `host_wr_sel` always equals bit 0 of the input count, so accepted packets alternate between buffer 0 and buffer 1.
- R4: A doorbell arriving while the occupancy before the edge is 2 does not advance the input count. `ovf_err` is then high for exactly the following cycle. This applies even if a consumer handshake happens at the same edge.
- R5: Each consumer handshake advances the output count by 1 modulo 16. `stat_out_cnt` is the 4-bit output count, and `cons_sel` equals bit 0 of the output count.
- R6: `cons_valid` is 1 exactly when the occupancy is non-zero. It falls in the cycle after the handshake that drains the last occupied buffer.
- R7: An accepted doorbell with length L stores ceil(L/4)·4 for its buffer. While `cons_valid` is high, `cons_len` shows the stored value for the buffer named by `cons_sel`.
- R8: A doorbell whose rounded length exceeds `BUF_BYTES` (1600 by default) does not advance the input count. `len_err` is then high for exactly the following cycle. A rounded length equal to `BUF_BYTES` is accepted.
- R9: Both counts wrap from 15 to 0. Occupancy, `host_free` and buffer alternation stay correct across the wrap.
- R10: An accepted doorbell and a handshake at the same edge both take effect, so the occupancy is unchanged and both counts advance.
- R11: `cons_ready` high while `cons_valid` is low leaves the output count, `cons_sel` and `stat_out_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| doorbell | input | 1 | Host signals that one packet has been copied (one cycle per packet) |
| doorbell_len | input | 12 | Byte length of the packet signalled by `doorbell` |
| host_free | output | 1 | A buffer is available to the host |
| host_wr_sel | output | 1 | Index of the buffer the host must fill next |
| stat_out_cnt | output | 4 | Output count status field |
| ovf_err | output | 1 | One-cycle flag: doorbell rejected because both buffers were full |
| len_err | output | 1 | One-cycle flag: doorbell rejected because its rounded length does not fit |
| cons_valid | output | 1 | A filled buffer is waiting for the consumer |
| cons_ready | input | 1 | Consumer has finished draining the presented buffer |
| cons_sel | output | 1 | Index of the buffer presented to the consumer |
| cons_len | output | 11 | Rounded byte length of the presented buffer |

## Verification
Every output is a direct function of the two counts and the two length registers, so a wrong count shows at the ports in the same cycle after the edge that corrupted it. A bad count appears as a wrong `host_wr_sel`, `stat_out_cnt` or `cons_sel`, or as a `host_free`/`cons_valid` pair that disagrees with the packets actually in flight. A wrongly latched length appears on `cons_len` as soon as that buffer is presented. The bench runs a behavioural model of both counts and both stored lengths and compares every output on every clock. It pays particular attention to the cycle after a full-state doorbell, the cycle after the last drain, and the wrap of the counts from 15 to 0.

// File: rtl/txpp_pkg.sv
package txpp_pkg;
  // two fixed buffers, used alternately
  localparam int NUM_BUF = 2;
  localparam int IDX_W   = $clog2(NUM_BUF);

  // outcome of one doorbell
  typedef struct packed {
    logic accept;
    logic overflow;
    logic oversize;
  } txpp_gate_t;
endpackage

// File: rtl/txpp_wrap_cnt.sv
module txpp_wrap_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= cnt + W'(1);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt == ($past(cnt) + W'(1)));  // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));  // R5
endmodule

// File: rtl/txpp_gate.sv
module txpp_gate
  import txpp_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int LEN_W     = 12,
  parameter int BUF_BYTES = 1600,
  parameter int ALIGN     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] in_cnt,
  input  logic [CNT_W-1:0] out_cnt,
  input  logic             doorbell,
  input  logic [LEN_W-1:0] doorbell_len,
  input  logic             cons_ready,
  output logic [CNT_W-1:0] occ,
  output logic             host_free,
  output logic             cons_valid,
  output logic             handshake,
  output txpp_gate_t       gate,
  output logic [LEN_W:0]   padded_len,
  output logic             ovf_err,
  output logic             len_err
);
  localparam logic [LEN_W:0] PAD_ADD = (LEN_W+1)'(ALIGN - 1);
  localparam logic [LEN_W:0] PAD_MSK = ~PAD_ADD;
  localparam logic [LEN_W:0] BUF_LIM = (LEN_W+1)'(BUF_BYTES);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(NUM_BUF);

  // modular difference of the two free-running counts
  assign occ        = in_cnt - out_cnt;
  assign host_free  = occ < FULL;
  assign cons_valid = occ != '0;
  assign handshake  = cons_valid && cons_ready;

  assign padded_len = ({1'b0, doorbell_len} + PAD_ADD) & PAD_MSK;

  always_comb begin
    gate.overflow = doorbell && !host_free;
    gate.oversize = doorbell && (padded_len > BUF_LIM);
    gate.accept   = doorbell && !gate.overflow && !gate.oversize;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_err <= 1'b0;
      len_err <= 1'b0;
    end else begin
      ovf_err <= gate.overflow;
      len_err <= gate.oversize;
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL);  // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (doorbell && !host_free) |=> (ovf_err && in_cnt == $past(in_cnt)));  // R4
  AST_LEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (doorbell && padded_len > BUF_LIM) |=> (len_err && $stable(in_cnt)));  // R8
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (handshake && occ == CNT_W'(1) && !doorbell) |=> !cons_valid);  // R6
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_ready && !cons_valid) |=> $stable(out_cnt));  // R11
  AST_BOTH_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (handshake && gate.accept) |=> $stable(occ));  // R10
endmodule

// File: rtl/txpp_slot_bank.sv
module txpp_slot_bank
  import txpp_pkg::*;
#(
  parameter int SLOT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [SLOT_W-1:0] wr_len,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [SLOT_W-1:0] rd_len
);
  logic [SLOT_W-1:0] slot_len [NUM_BUF];

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_len[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g)) slot_len[g] <= wr_len;
    end
  end

  assign rd_len = slot_len[rd_idx];

  AST_LEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_idx == wr_idx) |=> rd_len == $past(wr_len));  // R7
endmodule

// File: rtl/txpp_handoff.sv
module txpp_handoff
  import txpp_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int LEN_W     = 12,
  parameter int BUF_BYTES = 1600,
  parameter int ALIGN     = 4,
  localparam int SLOT_W   = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              doorbell,
  input  logic [LEN_W-1:0]  doorbell_len,
  output logic              host_free,
  output logic              host_wr_sel,
  output logic [CNT_W-1:0]  stat_out_cnt,
  output logic              ovf_err,
  output logic              len_err,
  output logic              cons_valid,
  input  logic              cons_ready,
  output logic              cons_sel,
  output logic [SLOT_W-1:0] cons_len
);
  logic [CNT_W-1:0] in_cnt, out_cnt, occ;
  logic             handshake;
  txpp_gate_t       gate;
  logic [LEN_W:0]   padded_len;

  txpp_wrap_cnt #(.W(CNT_W)) u_in_cnt (
    .clk(clk), .rst_n(rst_n), .step(gate.accept), .cnt(in_cnt));

  txpp_wrap_cnt #(.W(CNT_W)) u_out_cnt (
    .clk(clk), .rst_n(rst_n), .step(handshake), .cnt(out_cnt));

  txpp_gate #(
    .CNT_W(CNT_W), .LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES), .ALIGN(ALIGN)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .in_cnt(in_cnt), .out_cnt(out_cnt),
    .doorbell(doorbell), .doorbell_len(doorbell_len), .cons_ready(cons_ready),
    .occ(occ), .host_free(host_free), .cons_valid(cons_valid),
    .handshake(handshake), .gate(gate), .padded_len(padded_len),
    .ovf_err(ovf_err), .len_err(len_err));

  txpp_slot_bank #(.SLOT_W(SLOT_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .wr_en(gate.accept),
    .wr_idx(in_cnt[IDX_W-1:0]), .wr_len(padded_len[SLOT_W-1:0]),
    .rd_idx(out_cnt[IDX_W-1:0]), .rd_len(cons_len));

  assign host_wr_sel  = in_cnt[0];
  assign cons_sel     = out_cnt[0];
  assign stat_out_cnt = out_cnt;

  AST_PING_PONG: assert property (@(posedge clk) disable iff (!rst_n)
    gate.accept |=> host_wr_sel != $past(host_wr_sel));  // R3
  AST_SEL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    handshake |=> cons_sel != $past(cons_sel));  // R5
  AST_LEN_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    cons_valid |-> cons_len[1:0] == 2'b00);  // R7
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> !ovf_err || $past(doorbell));  // R4
endmodule

// File: tb/txpp_handoff_tb.sv
`timescale 1ns/1ps
module txpp_handoff_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        doorbell = 1'b0;
  logic [11:0] doorbell_len = '0;
  logic        cons_ready = 1'b0;
  logic        host_free, host_wr_sel, ovf_err, len_err, cons_valid, cons_sel;
  logic [3:0]  stat_out_cnt;
  logic [10:0] cons_len;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural reference
  int m_in = 0, m_out = 0;
  int m_len [2] = '{0, 0};
  bit m_ovf = 0, m_lerr = 0;

  always #4 clk = ~clk;  // 125 MHz

  txpp_handoff dut_i (
    .clk(clk), .rst_n(rst_n), .doorbell(doorbell), .doorbell_len(doorbell_len),
    .host_free(host_free), .host_wr_sel(host_wr_sel), .stat_out_cnt(stat_out_cnt),
    .ovf_err(ovf_err), .len_err(len_err), .cons_valid(cons_valid),
    .cons_ready(cons_ready), .cons_sel(cons_sel), .cons_len(cons_len));

  function automatic int pad4(input int l);
    return ((l + 3) / 4) * 4;
  endfunction

  function automatic int m_occ();
    return (m_in - m_out) & 15;
  endfunction

  task automatic check(input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check("R2 host_free", int'(host_free), int'(m_occ() < 2));
    check("R3 host_wr_sel", int'(host_wr_sel), m_in & 1);
    check("R5 stat_out_cnt", int'(stat_out_cnt), m_out);
    check("R5 cons_sel", int'(cons_sel), m_out & 1);
    check("R6 cons_valid", int'(cons_valid), int'(m_occ() != 0));
    check("R4 ovf_err", int'(ovf_err), int'(m_ovf));
    check("R8 len_err", int'(len_err), int'(m_lerr));
    if (m_occ() != 0) check("R7 cons_len", int'(cons_len), m_len[m_out & 1]);
  endtask

  task automatic step(input bit db, input int len, input bit rdy);
    int occ, p;
    bit acc;
    @(negedge clk);
    doorbell = db;
    doorbell_len = 12'(len);
    cons_ready = rdy;
    @(posedge clk);
    occ = m_occ();
    p = pad4(len);
    m_ovf = db && occ >= 2;
    m_lerr = db && p > 1600;
    acc = db && !m_ovf && !m_lerr;
    if (acc) begin
      m_len[m_in & 1] = p;
      m_in = (m_in + 1) & 15;
    end
    if (occ != 0 && rdy) m_out = (m_out + 1) & 15;
    #2;
    compare();
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 host_free", int'(host_free), 1);
    check("R1 host_wr_sel", int'(host_wr_sel), 0);
    check("R1 stat_out_cnt", int'(stat_out_cnt), 0);
    check("R1 cons_valid", int'(cons_valid), 0);
    check("R1 errors", int'(ovf_err) + int'(len_err), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R11 ready with nothing presented
    step(0, 0, 1);
    step(0, 0, 1);
    check("R11 stat_out_cnt idle", int'(stat_out_cnt), 0);

    // single packet, then drain; R6 drop after last drain
    step(1, 61, 0);
    check("R7 padded 61", int'(cons_len), 64);
    step(0, 0, 1);
    check("R6 valid dropped", int'(cons_valid), 0);

    // fill both, third doorbell overflows (R4)
    step(1, 100, 0);
    step(1, 5, 0);
    check("R2 full", int'(host_free), 0);
    step(1, 8, 0);
    check("R4 overflow flag", int'(ovf_err), 1);
    step(0, 0, 0);
    check("R4 flag one cycle", int'(ovf_err), 0);
    // R4 overflow with simultaneous drain still rejected
    step(1, 12, 1);
    check("R4 reject during drain", int'(ovf_err), 1);
    step(0, 0, 1);
    check("R6 empty", int'(cons_valid), 0);

    // R8 length limit edges
    step(1, 1601, 0);
    check("R8 oversize flagged", int'(len_err), 1);
    check("R8 oversize not queued", int'(cons_valid), 0);
    step(1, 1600, 0);
    check("R8 limit accepted", int'(cons_len), 1600);
    step(1, 1597, 1);
    check("R10 both moved", int'(cons_len), 1600);
    step(1, 4095, 1);
    step(1, 0, 1);
    step(0, 0, 1);
    step(0, 0, 1);

    // R9 wraparound streaming with mixed ready patterns
    for (int i = 0; i < 60; i++) step(1, (i * 37) % 1700, (i % 3) != 0);
    for (int i = 0; i < 4; i++) step(0, 0, 1);
    check("R9 drained after wrap", int'(cons_valid), 0);
    for (int i = 0; i < 40; i++) step((i % 2) == 0, 4 * i + 1, (i % 4) == 1);
    for (int i = 0; i < 4; i++) step(0, 0, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule